// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block maps each incoming bus address to a downstream target through a set of eight programmable windows. Every window has its own control register (enable, size mask, target number, attribute code), a base register and a two-part remap register. A lookup compares the upper sixteen address bits, the 64 KB page, against every enabled window at the same time. The lowest-numbered window that matches wins. The result gives that window's target and attribute and a translated address, which can be wider than the input address. When no window matches, a miss flag is raised instead.

A window's size field is a run of ones that starts at bit 0. Each set bit doubles the window, starting from a single 64 KB page. The field therefore also serves as the mask of page bits that the compare ignores and that the translation keeps from the incoming address. All page bits outside the mask are replaced by the remap value. Writing the remap value equal to the base gives an identity translation. A small register port with a word write and a registered word read sets up the windows. Lookups are pipelined with one register stage, so one lookup can start on every cycle.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every window is disabled and every register reads zero. A lookup then misses.
- R2: The register address is `cfg_addr[4:2]` = window and `cfg_addr[1:0]` = register. The register codes are 0 control, 1 base, 2 remap low, 3 remap high. The control layout is bit 0 enable, bits 7:4 target, bits 15:8 attribute, bits 31:16 size. Bits 3:1 read as zero. Base and remap low hold bits 31:16 and read zero in bits 15:0. Remap high holds bits 7:0 and reads zero above. Read data appears on `cfg_rdata` the cycle after `cfg_rd`, and it holds until the next read.
- R3: An enabled window matches when `(addr[31:16] ^ base) & ~size` is zero.
- R4: A size of 0x0000 covers exactly one 64 KB page, and 0x00FF covers 16 MB. An address one byte past the end of a window does not match it.
- R5: A disabled window never matches, even when its size and base would cover the address.
- R6: When several enabled windows match, the lowest-numbered one is reported.
- R7: On a hit, the translated address is `{remap_hi, (remap_lo & ~size) | (addr[31:16] & size), addr[15:0]}`.
- R8: A window whose remap low equals its base and whose remap high is zero passes the address through unchanged.
- R9: On a miss, `res_miss`=1, `res_hit`=0, and target, attribute and window index are zero. `res_addr` is the input address with the upper bits set to zero.
- R10: The result appears one cycle after `lk_valid`, and `res_valid` is high for exactly that cycle. A register write affects lookups that start in the cycle after the write.
- R11: `res_win` gives the index of the winning window on a hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 5 | Window index and register select |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Address to decode |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Address matched a window |
| res_miss | output | 1 | Address matched no window |
| res_win | output | 3 | Winning window index |
| res_target | output | 4 | Target number of winning window |
| res_attr | output | 8 | Attribute code of winning window |
| res_addr | output | 40 | Translated address |

## Verification
The assertions check several properties on every cycle. The grant is never more than one window, it always lies inside the set of matching windows, and no lower-numbered window also matched. They also check that a disabled window never raises a match. On each result exactly one of hit and miss is set, and the low sixteen address bits pass through unchanged. A control write is checked to show up in the window configuration on the next cycle. Only the bench scenarios can show the remaining behaviour: the translated upper bits, the exact window edges for the 64 KB and 16 MB sizes, priority among overlapping windows, register readback layout, and the one-cycle point at which a configuration change affects lookups.

// File: rtl/awd_pkg.sv
package awd_pkg;

    localparam int ADDR_W  = 32;
    localparam int OFF_W   = 16;
    localparam int PAGE_W  = ADDR_W - OFF_W;
    localparam int TGT_W   = 4;
    localparam int ATTR_W  = 8;
    localparam int RHI_W   = 8;
    localparam int XADDR_W = ADDR_W + RHI_W;
    localparam int CFG_DW  = 32;

    localparam int CTL_EN_BIT    = 0;
    localparam int CTL_TGT_LSB   = 4;
    localparam int CTL_ATTR_LSB  = 8;
    localparam int CTL_SIZE_LSB  = 16;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_BASE = 2'd1,
        SEL_RLO  = 2'd2,
        SEL_RHI  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              en;
        logic [TGT_W-1:0]  tgt;
        logic [ATTR_W-1:0] attr;
        logic [PAGE_W-1:0] size;
        logic [PAGE_W-1:0] base;
        logic [PAGE_W-1:0] rlo;
        logic [RHI_W-1:0]  rhi;
    } win_cfg_t;

endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
    import awd_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int IDX_W   = $clog2(NUM_WIN),
    parameter int CA_W    = IDX_W + 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_wr_i,
    input  logic                          cfg_rd_i,
    input  logic [CA_W-1:0]               cfg_addr_i,
    input  logic [CFG_DW-1:0]             cfg_wdata_i,
    output logic [CFG_DW-1:0]             cfg_rdata_o,
    output win_cfg_t [NUM_WIN-1:0]        cfg_o
);

    typedef struct packed {
        win_cfg_t [NUM_WIN-1:0] win;
        logic [CFG_DW-1:0]      rdata;
    } rf_state_t;

    rf_state_t st_d, st_q;

    logic [IDX_W-1:0] widx;
    reg_sel_e         wsel;
    logic             idx_ok;
    logic             ctrl_unused;

    assign widx        = cfg_addr_i[CA_W-1:2];
    assign wsel        = reg_sel_e'(cfg_addr_i[1:0]);
    assign idx_ok      = (int'(widx) < NUM_WIN);
    assign ctrl_unused = ^cfg_wdata_i[CTL_TGT_LSB-1:CTL_EN_BIT+1];

    always_comb begin
        st_d = st_q;
        if (cfg_wr_i && idx_ok) begin
            case (wsel)
                SEL_CTRL: begin
                    st_d.win[widx].en   = cfg_wdata_i[CTL_EN_BIT];
                    st_d.win[widx].tgt  = cfg_wdata_i[CTL_TGT_LSB +: TGT_W];
                    st_d.win[widx].attr = cfg_wdata_i[CTL_ATTR_LSB +: ATTR_W];
                    st_d.win[widx].size = cfg_wdata_i[CTL_SIZE_LSB +: PAGE_W];
                end
                SEL_BASE: st_d.win[widx].base = cfg_wdata_i[OFF_W +: PAGE_W];
                SEL_RLO:  st_d.win[widx].rlo  = cfg_wdata_i[OFF_W +: PAGE_W];
                default:  st_d.win[widx].rhi  = cfg_wdata_i[RHI_W-1:0];
            endcase
        end
        if (cfg_rd_i) begin
            st_d.rdata = '0;
            if (idx_ok) begin
                case (wsel)
                    SEL_CTRL: begin
                        st_d.rdata[CTL_EN_BIT]              = st_q.win[widx].en;
                        st_d.rdata[CTL_TGT_LSB +: TGT_W]    = st_q.win[widx].tgt;
                        st_d.rdata[CTL_ATTR_LSB +: ATTR_W]  = st_q.win[widx].attr;
                        st_d.rdata[CTL_SIZE_LSB +: PAGE_W]  = st_q.win[widx].size;
                    end
                    SEL_BASE: st_d.rdata[OFF_W +: PAGE_W] = st_q.win[widx].base;
                    SEL_RLO:  st_d.rdata[OFF_W +: PAGE_W] = st_q.win[widx].rlo;
                    default:  st_d.rdata[RHI_W-1:0]       = st_q.win[widx].rhi;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o       = st_q.win;
    assign cfg_rdata_o = st_q.rdata;

    // R2
    ctrl_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && idx_ok && wsel == SEL_CTRL)
        |=> (cfg_o[$past(widx)].size == $past(cfg_wdata_i[CTL_SIZE_LSB +: PAGE_W]))
            && (cfg_o[$past(widx)].en == $past(cfg_wdata_i[CTL_EN_BIT])));

endmodule

// File: rtl/awd_win_match.sv
module awd_win_match
    import awd_pkg::*;
#(
    parameter int NUM_WIN = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  win_cfg_t [NUM_WIN-1:0] cfg_i,
    input  logic [PAGE_W-1:0]      page_i,
    output logic [NUM_WIN-1:0]     match_o
);

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        logic [PAGE_W-1:0] diff_d;
        assign diff_d     = (page_i ^ cfg_i[g].base) & ~cfg_i[g].size;
        assign match_o[g] = cfg_i[g].en && (diff_d == '0);

        // R5
        disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_i[g].en |-> !match_o[g]);
    end

endmodule

// File: rtl/awd_prio_pick.sv
module awd_prio_pick #(
    parameter int NUM_WIN = 8,
    parameter int IDX_W   = $clog2(NUM_WIN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_WIN-1:0] match_i,
    output logic [NUM_WIN-1:0] grant_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic               any_o
);

    always_comb begin
        grant_o = '0;
        idx_o   = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (match_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
                idx_o      = IDX_W'(i);
            end
        end
        any_o = |match_i;
    end

    // R6
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o) && (any_o == (grant_o != '0)));

    // R6
    grant_in_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~match_i) == '0);

    // R6
    lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_o - NUM_WIN'(1)) & match_i) == '0);

endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
    import awd_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int IDX_W   = $clog2(NUM_WIN),
    parameter int CA_W    = IDX_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic               cfg_rd,
    input  logic [CA_W-1:0]    cfg_addr,
    input  logic [CFG_DW-1:0]  cfg_wdata,
    output logic [CFG_DW-1:0]  cfg_rdata,
    input  logic               lk_valid,
    input  logic [ADDR_W-1:0]  lk_addr,
    output logic               res_valid,
    output logic               res_hit,
    output logic               res_miss,
    output logic [IDX_W-1:0]   res_win,
    output logic [TGT_W-1:0]   res_target,
    output logic [ATTR_W-1:0]  res_attr,
    output logic [XADDR_W-1:0] res_addr
);

    typedef struct packed {
        logic               valid;
        logic               hit;
        logic               miss;
        logic [IDX_W-1:0]   win;
        logic [TGT_W-1:0]   tgt;
        logic [ATTR_W-1:0]  attr;
        logic [XADDR_W-1:0] xaddr;
    } res_t;

    win_cfg_t [NUM_WIN-1:0] win_cfg;
    logic [NUM_WIN-1:0]     match_vec;
    logic [NUM_WIN-1:0]     grant_vec;
    logic [IDX_W-1:0]       win_idx;
    logic                   any_hit;
    logic [PAGE_W-1:0]      lk_page;
    logic [PAGE_W-1:0]      sel_size;
    logic [PAGE_W-1:0]      sel_rlo;
    logic [RHI_W-1:0]       sel_rhi;
    logic [TGT_W-1:0]       sel_tgt;
    logic [ATTR_W-1:0]      sel_attr;
    logic                   grant_unused;
    res_t                   res_d, res_q;

    assign lk_page      = lk_addr[ADDR_W-1:OFF_W];
    assign grant_unused = ^grant_vec;

    awd_regfile #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W), .CA_W(CA_W)) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_i    (cfg_wr),
        .cfg_rd_i    (cfg_rd),
        .cfg_addr_i  (cfg_addr),
        .cfg_wdata_i (cfg_wdata),
        .cfg_rdata_o (cfg_rdata),
        .cfg_o       (win_cfg)
    );

    awd_win_match #(.NUM_WIN(NUM_WIN)) match_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_i   (win_cfg),
        .page_i  (lk_page),
        .match_o (match_vec)
    );

    awd_prio_pick #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) pick_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .match_i (match_vec),
        .grant_o (grant_vec),
        .idx_o   (win_idx),
        .any_o   (any_hit)
    );

    assign sel_size = win_cfg[win_idx].size;
    assign sel_rlo  = win_cfg[win_idx].rlo;
    assign sel_rhi  = win_cfg[win_idx].rhi;
    assign sel_tgt  = win_cfg[win_idx].tgt;
    assign sel_attr = win_cfg[win_idx].attr;

    always_comb begin
        res_d       = '0;
        res_d.valid = lk_valid;
        res_d.xaddr = XADDR_W'(lk_addr);
        if (lk_valid) begin
            if (any_hit) begin
                res_d.hit   = 1'b1;
                res_d.win   = win_idx;
                res_d.tgt   = sel_tgt;
                res_d.attr  = sel_attr;
                res_d.xaddr = {sel_rhi,
                               (sel_rlo & ~sel_size) | (lk_page & sel_size),
                               lk_addr[OFF_W-1:0]};
            end else begin
                res_d.miss  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid  = res_q.valid;
    assign res_hit    = res_q.hit;
    assign res_miss   = res_q.miss;
    assign res_win    = res_q.win;
    assign res_target = res_q.tgt;
    assign res_attr   = res_q.attr;
    assign res_addr   = res_q.xaddr;

    // R9
    hit_xor_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid ? (res_hit != res_miss) : (!res_hit && !res_miss));

    // R10
    one_cycle_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    // R7
    offset_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (res_addr[OFF_W-1:0] == $past(lk_addr[OFF_W-1:0])));

endmodule

// File: tb/addr_window_decoder_tb.sv
module addr_window_decoder_tb_top;

    localparam int NW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_rd = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        res_valid, res_hit, res_miss;
    logic [2:0]  res_win;
    logic [3:0]  res_target;
    logic [7:0]  res_attr;
    logic [39:0] res_addr;

    always #2 clk = ~clk;

    addr_window_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .res_valid(res_valid),
        .res_hit(res_hit), .res_miss(res_miss), .res_win(res_win),
        .res_target(res_target), .res_attr(res_attr), .res_addr(res_addr)
    );

    typedef struct {
        logic        hit;
        logic [2:0]  win;
        logic [3:0]  tgt;
        logic [7:0]  attr;
        logic [39:0] xaddr;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk = 0;
    int   n_err = 0;

    logic        sh_en   [NW];
    logic [3:0]  sh_tgt  [NW];
    logic [7:0]  sh_attr [NW];
    logic [15:0] sh_size [NW];
    logic [15:0] sh_base [NW];
    logic [15:0] sh_rlo  [NW];
    logic [7:0]  sh_rhi  [NW];

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input int w, input int sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 5'((w << 2) | sel); cfg_wdata = d;
        case (sel)
            0: begin sh_en[w] = d[0]; sh_tgt[w] = d[7:4]; sh_attr[w] = d[15:8]; sh_size[w] = d[31:16]; end
            1: sh_base[w] = d[31:16];
            2: sh_rlo[w]  = d[31:16];
            default: sh_rhi[w] = d[7:0];
        endcase
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic set_win(input int w, input bit en, input logic [3:0] t, input logic [7:0] a,
                           input logic [15:0] sz, input logic [15:0] b, input logic [15:0] rl,
                           input logic [7:0] rh);
        reg_wr(w, 0, {sz, a, t, 3'b000, en});
        reg_wr(w, 1, {b, 16'h0000});
        reg_wr(w, 2, {rl, 16'h0000});
        reg_wr(w, 3, {24'h0, rh});
    endtask

    task automatic reg_rd_chk(input int w, input int sel, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_rd = 1'b1; cfg_addr = 5'((w << 2) | sel);
        @(posedge clk); #1;
        cfg_rd = 1'b0;
        @(negedge clk);
        check(cfg_rdata === exp, tag, 64'(cfg_rdata), 64'(exp));
    endtask

    task automatic lookup(input logic [31:0] a, input string tag);
        exp_t e;
        e.hit = 1'b0; e.win = '0; e.tgt = '0; e.attr = '0; e.xaddr = {8'h00, a}; e.tag = tag;
        for (int i = 0; i < NW; i++) begin
            if (!e.hit && sh_en[i] && (((a[31:16] ^ sh_base[i]) & ~sh_size[i]) == 16'h0)) begin
                e.hit   = 1'b1;
                e.win   = 3'(i);
                e.tgt   = sh_tgt[i];
                e.attr  = sh_attr[i];
                e.xaddr = {sh_rhi[i], (sh_rlo[i] & ~sh_size[i]) | (a[31:16] & sh_size[i]), a[15:0]};
            end
        end
        @(negedge clk);
        sb_q.push_back(e);
        lk_valid = 1'b1; lk_addr = a;
        @(posedge clk); #1;
        lk_valid = 1'b0;
    endtask

    // monitor: compares every result against the oldest expected item
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R10 unexpected result", 64'(res_addr), 64'h0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(res_hit === e.hit && res_miss === !e.hit, {e.tag, " hit/miss"},
                      64'({res_hit, res_miss}), 64'({e.hit, !e.hit}));
                check(res_win === e.win, {e.tag, " R11 window"}, 64'(res_win), 64'(e.win));
                check(res_target === e.tgt && res_attr === e.attr, {e.tag, " target/attr"},
                      64'({res_target, res_attr}), 64'({e.tgt, e.attr}));
                check(res_addr === e.xaddr, {e.tag, " translated address"},
                      64'(res_addr), 64'(e.xaddr));
            end
        end
    end

    bit done = 1'b0;

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 64'h0, 64'h1);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < NW; i++) begin
            sh_en[i] = 1'b0; sh_tgt[i] = '0; sh_attr[i] = '0;
            sh_size[i] = '0; sh_base[i] = '0; sh_rlo[i] = '0; sh_rhi[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        check(res_valid === 1'b0 && res_hit === 1'b0 && res_miss === 1'b0, "R1 result idle after reset",
              64'({res_valid, res_hit, res_miss}), 64'h0);
        reg_rd_chk(0, 0, 32'h0, "R1 control reads zero after reset");
        reg_rd_chk(7, 1, 32'h0, "R1 base reads zero after reset");
        lookup(32'h1234_5678, "R1 R9 unconfigured lookup misses");

        // R2: register layout and readback
        reg_wr(3, 0, 32'hABCD_5A3F);
        reg_wr(3, 1, 32'h1234_FFFF);
        reg_wr(3, 2, 32'h5678_0001);
        reg_wr(3, 3, 32'hFFFF_FF77);
        reg_rd_chk(3, 0, 32'hABCD_5A31, "R2 control readback, bits 3:1 zero");
        reg_rd_chk(3, 1, 32'h1234_0000, "R2 base readback");
        reg_rd_chk(3, 2, 32'h5678_0000, "R2 remap low readback");
        reg_rd_chk(3, 3, 32'h0000_0077, "R2 remap high readback");
        @(negedge clk);
        check(cfg_rdata === 32'h0000_0077, "R2 read data holds", 64'(cfg_rdata), 64'h77);

        // window map
        set_win(0, 1'b1, 4'h1, 8'h11, 16'h0FFF, 16'hE000, 16'hE000, 8'h00);
        set_win(1, 1'b1, 4'h1, 8'h22, 16'h0000, 16'hF200, 16'hC000, 8'h00);
        set_win(2, 1'b1, 4'h2, 8'h33, 16'h00FF, 16'hD000, 16'h4500, 8'h5A);
        set_win(3, 1'b0, 4'h7, 8'h66, 16'hFFFF, 16'h0000, 16'h0000, 8'h00);
        set_win(4, 1'b1, 4'h5, 8'h44, 16'h00FF, 16'hE800, 16'hE800, 8'h00);
        set_win(5, 1'b1, 4'h6, 8'h55, 16'h0003, 16'h8004, 16'h9000, 8'h01);

        lookup(32'hE123_4567, "R8 R3 identity window");
        lookup(32'hE8AB_CDEF, "R6 overlap lowest wins");
        lookup(32'hF200_1234, "R4 R7 64KB window remap");
        lookup(32'hF201_0000, "R4 R9 one past 64KB misses");
        lookup(32'hD000_0000, "R4 R7 16MB window first byte");
        lookup(32'hD0FF_FFFF, "R4 R7 16MB window last byte");
        lookup(32'hD100_0000, "R4 one past 16MB misses");
        lookup(32'h8006_ABCD, "R3 R7 256KB window");
        lookup(32'h8008_0000, "R3 R9 above 256KB misses");
        lookup(32'h0000_0000, "R5 disabled window never matches");

        // R10: configuration change seen by the next lookup
        reg_wr(3, 0, 32'hFFFF_6671);
        lookup(32'h0000_0000, "R10 R11 enabled window now hits");
        reg_wr(0, 0, 32'h0FFF_1110);
        lookup(32'hE123_4567, "R10 R6 lookup after disabling window 0");

        repeat (3) @(negedge clk);
        check(res_valid === 1'b0, "R10 valid drops after result", 64'(res_valid), 64'h0);
        check(sb_q.size() == 0, "R10 every lookup answered", 64'(sb_q.size()), 64'h0);
        done = 1'b1;
        finish_run();
    end

endmodule